// File: doc/BRIEF.md
# SPI Operation-Queue Sequencer

This block runs one single-lane SPI flash port from a queue of operations issued by software. Each operation is a 14-bit word that pairs an operation code with a byte count. Some codes only move chip select. The transmit code shifts a counted burst out of a byte-wide data FIFO. The receive code shifts a counted burst in and stores each byte in that same data FIFO. The sequencer drives chip select, SCLK and MOSI, samples MISO, and takes one queued operation at a time.

Software accepts operations and transmit bytes through valid/ready inputs and collects received bytes through a valid/ready output. A transfer happens on any clock edge where valid and ready are both high. When ready is low, the source must hold its word. When valid is low on the output side, `rd_byte` has no meaning. Operation codes that the block does not know are taken from the queue and dropped. Transfers longer than 511 bytes are split by software into several entries. A dummy byte is an ordinary transmit byte of value 0xFF.

Top module: `spi_opq_seq`

## Requirements
- R1: An operation word carries the byte count in bits [8:0] and the operation code in bits [13:9]. `op_ready` is high exactly when the operation queue (OP_DEPTH entries) has room, and a word is accepted when `op_valid` and `op_ready` are both high.
- R2: Code 0x01 drives `spi_cs_n` low and code 0x00 drives it high. Neither code produces an SCLK edge, and both ignore their count field.
- R3: Code 0x08 sends `count` bytes taken from the data FIFO in arrival order, MSB first, in SPI mode 0: SCLK idles low, MOSI is stable at each rising edge, and MOSI changes only after a falling edge.
- R4: Code 0x0C samples MISO on each SCLK rising edge, MSB first, and places `count` received bytes into the data FIFO. Software reads them in order through `rd_byte`/`rd_valid`/`rd_ready`.
- R5: While a transmit operation still owes bytes and the data FIFO is empty, SCLK stays low and the operation does not complete.
- R6: A receive operation does not start a byte while the data FIFO (DATA_DEPTH bytes) is full. It resumes after software pops a byte, so exactly DATA_DEPTH bytes are clocked before the stall.
- R7: SCLK is high for CLK_DIV system clocks and low for CLK_DIV system clocks, and every byte has 8 rising edges.
- R8: Any code other than 0x00, 0x01, 0x08 and 0x0C is removed from the queue with no effect on `spi_cs_n`, SCLK or the data FIFO.
- R9: A transmit or receive operation whose count is 0 completes without any SCLK edge.
- R10: `op_drained` is high exactly when the operation queue is empty and no operation is in progress.
- R11: `wr_ready` is low while a receive operation is in progress, and `rd_valid` is low while a transmit operation is in progress.
- R12: After reset, `spi_cs_n` is 1, SCLK is 0, `op_ready` and `wr_ready` are 1, `op_drained` is 1 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation word offered |
| op_ready | output | 1 | Operation queue has room |
| op_word | input | 14 | {code[4:0], count[8:0]} |
| op_drained | output | 1 | Queue empty and sequencer idle |
| wr_valid | input | 1 | Transmit byte offered |
| wr_ready | output | 1 | Data FIFO accepts a transmit byte |
| wr_byte | input | 8 | Transmit byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Pop the presented received byte |
| rd_byte | output | 8 | Oldest data-FIFO byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is a receive operation stalled on a full data FIFO. The stall only happens when the count is larger than the FIFO depth and software does not read anything back. The bench queues a 20-byte receive with no reads, waits until the SCLK edge count stops at exactly 128, and checks that the sequencer is stalled and that transmit writes are refused. It then drains all 20 bytes against the slave's pattern. A second stalled state, a transmit operation waiting on an empty FIFO, is held open long enough to fill the operation queue behind it.

// File: rtl/spi_opq_pkg.sv
package spi_opq_pkg;
  localparam int LEN_W   = 9;
  localparam int OPC_W   = 5;
  localparam int ENTRY_W = LEN_W + OPC_W;

  localparam logic [OPC_W-1:0] OPC_CS_HIGH = 5'h00;
  localparam logic [OPC_W-1:0] OPC_CS_LOW  = 5'h01;
  localparam logic [OPC_W-1:0] OPC_TX      = 5'h08;
  localparam logic [OPC_W-1:0] OPC_RX      = 5'h0C;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [LEN_W-1:0] len;
  } op_entry_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_EXEC, SQ_BUSY} seq_state_t;
endpackage

// File: rtl/spi_opq_fifo.sv
module spi_opq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/spi_opq_shifter.sv
module spi_opq_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_RELOAD = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sh, rx_sh;

  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        sclk    <= 1'b0;
        div_cnt <= DIV_RELOAD;
        bit_cnt <= '0;
        tx_sh   <= tx_byte;
      end else if (busy) begin
        if (div_cnt != '0) begin
          div_cnt <= div_cnt - 1'b1;
        end else begin
          div_cnt <= DIV_RELOAD;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  assert_start_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_opq_ctrl.sv
module spi_opq_ctrl
  import spi_opq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      op_empty,
  input  op_entry_t op_head,
  output logic      op_pop,
  input  logic      d_empty,
  input  logic      d_full,
  input  logic [7:0] d_head,
  output logic      tx_pop,
  output logic      rx_push,
  output logic      sh_start,
  output logic [7:0] sh_byte,
  input  logic      sh_done,
  output logic      cs_n,
  output logic      tx_active,
  output logic      rx_active,
  output logic      idle
);
  seq_state_t       st;
  op_entry_t        cur;
  logic [LEN_W-1:0] rem;
  logic             is_tx, is_rx, tx_go, rx_go;

  assign is_tx     = (cur.opc == OPC_TX);
  assign is_rx     = (cur.opc == OPC_RX);
  assign tx_go     = (st == SQ_EXEC) && is_tx && (rem != '0) && !d_empty;
  assign rx_go     = (st == SQ_EXEC) && is_rx && (rem != '0) && !d_full;
  assign op_pop    = (st == SQ_IDLE) && !op_empty;
  assign tx_pop    = tx_go;
  assign sh_start  = tx_go || rx_go;
  assign sh_byte   = tx_go ? d_head : 8'hFF;
  assign rx_push   = (st == SQ_BUSY) && sh_done && is_rx;
  assign idle      = (st == SQ_IDLE);
  assign tx_active = (st != SQ_IDLE) && is_tx;
  assign rx_active = (st != SQ_IDLE) && is_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_IDLE;
      cur  <= '0;
      rem  <= '0;
      cs_n <= 1'b1;
    end else begin
      case (st)
        SQ_IDLE: if (!op_empty) begin
          cur <= op_head;
          rem <= op_head.len;
          st  <= SQ_EXEC;
        end
        SQ_EXEC: begin
          if (cur.opc == OPC_CS_LOW) begin
            cs_n <= 1'b0;
            st   <= SQ_IDLE;
          end else if (cur.opc == OPC_CS_HIGH) begin
            cs_n <= 1'b1;
            st   <= SQ_IDLE;
          end else if (is_tx || is_rx) begin
            if (rem == '0) begin
              st <= SQ_IDLE;
            end else if (tx_go || rx_go) begin
              rem <= rem - 1'b1;
              st  <= SQ_BUSY;
            end
          end else begin
            st <= SQ_IDLE;
          end
        end
        SQ_BUSY: if (sh_done) st <= SQ_EXEC;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_cs_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_EXEC && cur.opc != OPC_CS_LOW && cur.opc != OPC_CS_HIGH) |=> $stable(cs_n));
  assert_rx_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !d_full);
  assert_tx_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && is_tx) |-> !d_empty);
endmodule

// File: rtl/spi_opq_seq.sv
module spi_opq_seq
  import spi_opq_pkg::*;
#(
  parameter int OP_DEPTH   = 4,
  parameter int DATA_DEPTH = 16,
  parameter int CLK_DIV    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [ENTRY_W-1:0] op_word,
  output logic               op_drained,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [7:0]         wr_byte,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [7:0]         rd_byte,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  logic             op_full, op_empty, op_pop;
  logic [ENTRY_W-1:0] op_head_w;
  logic             d_full, d_empty, d_push, d_pop;
  logic [7:0]       d_din, d_head;
  logic             tx_pop, rx_push, sh_start, sh_done, sh_busy;
  logic [7:0]       sh_byte, sh_rx;
  logic             tx_active, rx_active, seq_idle;
  logic             wr_take, rd_take;

  assign op_ready   = !op_full;
  assign op_drained = op_empty && seq_idle;
  assign wr_ready   = !d_full && !rx_active;
  assign rd_valid   = !d_empty && !tx_active;
  assign rd_byte    = d_head;
  assign wr_take    = wr_valid && wr_ready;
  assign rd_take    = rd_valid && rd_ready;
  assign d_push     = wr_take || rx_push;
  assign d_din      = rx_push ? sh_rx : wr_byte;
  assign d_pop      = rd_take || tx_pop;

  spi_opq_fifo #(.W(ENTRY_W), .DEPTH(OP_DEPTH)) u_opq (
    .clk(clk), .rst_n(rst_n), .push(op_valid && op_ready), .din(op_word),
    .pop(op_pop), .dout(op_head_w), .full(op_full), .empty(op_empty));

  spi_opq_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .push(d_push), .din(d_din),
    .pop(d_pop), .dout(d_head), .full(d_full), .empty(d_empty));

  spi_opq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_empty(op_empty), .op_head(op_entry_t'(op_head_w)),
    .op_pop(op_pop), .d_empty(d_empty), .d_full(d_full), .d_head(d_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .sh_start(sh_start), .sh_byte(sh_byte),
    .sh_done(sh_done), .cs_n(spi_cs_n), .tx_active(tx_active),
    .rx_active(rx_active), .idle(seq_idle));

  spi_opq_shifter #(.CLK_DIV(CLK_DIV)) u_sh (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_byte),
    .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .sclk(spi_sclk),
    .mosi(spi_mosi), .miso(spi_miso));

  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_take && rx_push) && !(rd_take && tx_pop));
  assert_drained_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_drained |-> !sh_busy);
endmodule

// File: tb/spi_opq_seq_test.sv
`timescale 1ns/1ps
module spi_opq_seq_test;
  localparam int OPD = 4;
  localparam int DD  = 16;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [13:0] op_word = '0;
  logic [7:0]  wr_byte = '0;
  logic op_ready, op_drained, wr_ready, rd_valid;
  logic [7:0] rd_byte;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_opq_seq #(.OP_DEPTH(OPD), .DATA_DEPTH(DD), .CLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .op_drained(op_drained), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_byte(wr_byte), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_byte(rd_byte), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int checks = 0, failures = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int rise_cyc [2];
  logic [7:0] cap [64];
  int cap_n = 0, nbit = 0, mbit = 0, miso_k = 0;
  logic [7:0] sh_in = '0, miso_sh = '0, miso_seed = '0;

  // {rx, count, seed}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'd1,  8'h81}, {1'b0, 8'd5, 8'h10}, {1'b1, 8'd3,  8'hC3},
    {1'b0, 8'd12, 8'hFF}, {1'b1, 8'd16, 8'h07}, {1'b1, 8'd1, 8'h5A}};

  function automatic logic [7:0] patt(logic [7:0] seed, int k);
    return seed + 8'(k * 17);
  endfunction

  assign spi_miso = miso_sh[7];

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge spi_sclk) begin
    if (rise_cnt < 2) rise_cyc[rise_cnt] = cyc;
    rise_cnt = rise_cnt + 1;
    if (!spi_cs_n) begin
      sh_in = {sh_in[6:0], spi_mosi};
      nbit = nbit + 1;
      if (nbit == 8) begin
        nbit = 0;
        if (cap_n < 64) cap[cap_n] = sh_in;
        cap_n = cap_n + 1;
      end
    end
  end

  always @(negedge spi_cs_n) begin
    nbit = 0; cap_n = 0; mbit = 0; miso_k = 0;
    miso_sh = patt(miso_seed, 0);
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      mbit = mbit + 1;
      if (mbit == 8) begin
        mbit = 0;
        miso_k = miso_k + 1;
        miso_sh = patt(miso_seed, miso_k);
      end else begin
        miso_sh = {miso_sh[6:0], 1'b0};
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_op(logic [4:0] opc, logic [8:0] len);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_word = {opc, len};
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic push_wr(logic [7:0] b);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_byte = b;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_rd(output logic [7:0] b);
    int t = 0;
    @(negedge clk);
    while (!rd_valid && t < 3000) begin @(negedge clk); t++; end
    b = rd_byte;
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_drained(string tag);
    int t = 0;
    @(negedge clk);
    while (!op_drained && t < 5000) begin @(negedge clk); t++; end
    chk(tag, op_drained, 1);
  endtask

  task automatic run_all();
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 cs_n", spi_cs_n, 1);
    chk("R12 sclk", spi_sclk, 0);
    chk("R12 op_ready", op_ready, 1);
    chk("R12 wr_ready", wr_ready, 1);
    chk("R12 op_drained", op_drained, 1);
    chk("R12 rd_valid", rd_valid, 0);

    // vector table walk: R3 transmit, R4 receive
    for (int v = 0; v < 6; v++) begin
      logic rx = VEC[v][16];
      int len = int'(VEC[v][15:8]);
      logic [7:0] seed = VEC[v][7:0];
      int bad = 0;
      rise_cnt = 0;
      miso_seed = seed;
      push_op(5'h01, 9'd1);
      if (rx) begin
        push_op(5'h0C, 9'(len));
        push_op(5'h00, 9'd1);
        wait_drained("R10 rx vector drained");
        for (int k = 0; k < len; k++) begin
          pop_rd(b);
          if (b !== patt(seed, k)) bad++;
        end
        chk("R4 rx bytes mismatches", bad, 0);
      end else begin
        push_op(5'h08, 9'(len));
        for (int k = 0; k < len; k++) push_wr(patt(seed, k));
        push_op(5'h00, 9'd1);
        wait_drained("R10 tx vector drained");
        for (int k = 0; k < len; k++) if (cap[k] !== patt(seed, k)) bad++;
        chk("R3 tx byte count", cap_n, len);
        chk("R3 tx bytes mismatches", bad, 0);
      end
      chk("R7 rising edges per vector", rise_cnt, 8 * len);
    end

    // R9 zero-length transfers
    rise_cnt = 0;
    push_op(5'h08, 9'd0);
    push_op(5'h0C, 9'd0);
    wait_drained("R9 zero length drained");
    chk("R9 no sclk edges", rise_cnt, 0);
    chk("R9 no rx data", rd_valid, 0);

    // R8 unknown opcode
    push_op(5'h1F, 9'd5);
    push_op(5'h13, 9'd2);
    wait_drained("R8 unknown drained");
    chk("R8 cs_n unchanged", spi_cs_n, 1);
    chk("R8 no sclk edges", rise_cnt, 0);
    chk("R8 data fifo untouched", rd_valid, 0);

    // R5 transmit stall on empty data FIFO, R1 queue full, R2 chip select
    push_op(5'h01, 9'd1);
    push_op(5'h08, 9'd2);
    repeat (60) @(negedge clk);
    chk("R5 no sclk while starved", rise_cnt, 0);
    chk("R5 not drained while starved", op_drained, 0);
    chk("R2 cs_n low after 0x01", spi_cs_n, 0);
    for (int k = 0; k < OPD; k++) push_op((k == 0) ? 5'h00 : 5'h1E, 9'd1);
    @(negedge clk);
    chk("R1 op_ready low when queue full", op_ready, 0);
    push_wr(8'hA5);
    push_wr(8'h3C);
    repeat (4) @(negedge clk);
    chk("R11 rd_valid masked during tx", rd_valid, 0);
    chk("R11 wr_ready open during tx", wr_ready, 1);
    wait_drained("R10 stall test drained");
    chk("R3 stalled byte 0", cap[0], 8'hA5);
    chk("R3 stalled byte 1", cap[1], 8'h3C);
    chk("R2 cs_n high after 0x00", spi_cs_n, 1);
    chk("R7 sclk period cycles", rise_cyc[1] - rise_cyc[0], 2 * DIV);

    // R6 receive stall on full data FIFO
    rise_cnt = 0;
    miso_seed = 8'h29;
    push_op(5'h01, 9'd1);
    push_op(5'h0C, 9'd20);
    push_op(5'h00, 9'd1);
    repeat (1200) @(negedge clk);
    chk("R6 edges stop at full FIFO", rise_cnt, 8 * DD);
    chk("R6 not drained while full", op_drained, 0);
    chk("R11 wr_ready low during rx", wr_ready, 0);
    chk("R6 data waiting", rd_valid, 1);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        pop_rd(b);
        if (b !== patt(8'h29, k)) bad++;
      end
      chk("R6 resumed rx mismatches", bad, 0);
    end
    wait_drained("R10 rx stall drained");
    chk("R6 total edges", rise_cnt, 8 * 20);
    chk("R10 fifo empty at end", rd_valid, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule